// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller services a cache read miss. When a miss arrives it records the line address and the missed word offset. It then issues one request to memory that names the line and the starting word. Memory returns the line one word per beat, starting at the missed word and wrapping around the end of the line. The controller writes every returned word into the line storage through a line-write port. It also forwards the first word straight to the processor in the cycle it arrives, so the processor restarts without waiting for the rest of the line. Once the last word has been written, the controller pulses a line-valid strobe and becomes ready for the next miss.

While a fill is running, the controller keeps a record of which words have already been written. A processor hit on the line being filled is let through only for those words. A hit on any other word of that line is stalled. Hits on other lines, and hits while no fill is active, are never stalled. Memory may leave gaps between beats by holding its valid low. Gaps only delay the fill and never change the order of the writes.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1, and `mem_req_valid`, `mem_rready`, `lw_en`, `cpu_rvalid`, `line_valid` and `hit_stall` are all 0.
- R2: A miss is accepted only in a cycle where `miss_valid` and `miss_ready` are both 1. `miss_ready` then stays 0 from the cycle after acceptance through the cycle in which `line_valid` is 1.
- R3: In the cycle after a miss is accepted, `mem_req_valid` is 1, with `mem_req_line` equal to the miss line and `mem_req_off` equal to the miss offset.
- R4: Beat k of the fill (k = 0..WORDS-1, counting only accepted beats) is written with `lw_idx` = (critical offset + k) mod WORDS and `lw_data` equal to the beat's data. The order therefore wraps from the last word back to word 0.
- R5: `cpu_rvalid` is 1 in exactly one cycle per miss: the cycle in which beat 0 is accepted. In that cycle `cpu_rdata` equals that beat's data.
- R6: `lw_en` is 1 only in a cycle with `mem_rvalid` and `mem_rready` both 1. A cycle with `mem_rvalid` low writes nothing and does not advance the beat order.
- R7: `line_valid` is 1 for exactly one cycle, the cycle after the last beat is accepted. It is 0 at all other times.
- R8: `hit_stall` is 1 when `hit_valid` is 1, a fill is in progress, `hit_line` equals the line being filled, and word `hit_off` has not yet been written. It is 0 for an already written word, for another line, and when no fill is active.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with unchanged line and offset.
- R10: `mem_rready` is 1 only between the accepted memory request and the last beat, and never while `miss_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Read miss request |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_off | input | log2(WORDS) | Missed word offset in the line |
| miss_ready | output | 1 | Controller can accept a miss |
| mem_req_valid | output | 1 | Line read request to memory |
| mem_req_line | output | LINE_AW | Requested line address |
| mem_req_off | output | log2(WORDS) | First word memory must return |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Memory data beat valid |
| mem_rdata | input | DATA_W | Memory data beat |
| mem_rready | output | 1 | Controller accepts a data beat |
| cpu_rvalid | output | 1 | Early-restart strobe for the missed word |
| cpu_rdata | output | DATA_W | Missed word returned to the processor |
| lw_en | output | 1 | Line storage write enable |
| lw_idx | output | log2(WORDS) | Word index written |
| lw_data | output | DATA_W | Word written |
| line_valid | output | 1 | One-cycle strobe: line completely filled |
| hit_valid | input | 1 | Processor hit probe |
| hit_line | input | LINE_AW | Line address of the hit |
| hit_off | input | log2(WORDS) | Word offset of the hit |
| hit_stall | output | 1 | Hit must wait for the fill |

## Verification
A wrong start value in the beat counter, or a wrong wrap, shows up at the line-write port with the first or the wrapped beat: `lw_idx` is already wrong in the cycle beat 0 or the first wrapped beat is accepted. A state machine that lingers or leaves a state too early moves the early-restart strobe or the line-valid pulse by a whole beat, or lets `miss_ready` rise during a fill, so it is visible within one beat. The sweep repeats the fill once for every critical offset, with and without gaps in the memory data. It compares the last-word timing, the strobe cycles and the fully assembled line against values the bench computes from the offset alone. A stale written-word mask shows as a wrong `hit_stall` within the cycle it is probed.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_REQ       = 3'd1,
        ST_WAIT_CRIT = 3'd2,
        ST_FILL_REST = 3'd3,
        ST_DONE      = 3'd4
    } fill_state_e;

endpackage

// File: rtl/cwf_beat_seq.sv
// Wrapped word index sequencer: index = (base + count) mod WORDS.
module cwf_beat_seq #(
    parameter int WORDS = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OFF_W-1:0] start_off,
    input  logic             adv,
    output logic [OFF_W-1:0] idx_o,
    output logic             last_o
);
    typedef struct packed {
        logic [OFF_W-1:0] base;
        logic [OFF_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.base = start_off;
            seq_d.cnt  = '0;
        end else if (adv) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // Power-of-two line size: truncation performs the modulo.
    assign idx_o  = seq_q.base + seq_q.cnt;
    assign last_o = (seq_q.cnt == OFF_W'(WORDS - 1));
endmodule

// File: rtl/cwf_fill_mask.sv
// Tracks which words of the line in flight have been written.
module cwf_fill_mask #(
    parameter int WORDS = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set_en,
    input  logic [OFF_W-1:0] set_idx,
    input  logic [OFF_W-1:0] probe_idx,
    output logic             filled_o
);
    logic [WORDS-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (clr) begin
            mask_d = '0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (set_en && set_idx == OFF_W'(w)) mask_d[w] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign filled_o = mask_q[probe_idx];
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl
    import cwf_pkg::*;
#(
    parameter int LINE_AW = 26,
    parameter int WORDS   = 8,
    parameter int DATA_W  = 32,
    localparam int OFF_W  = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [LINE_AW-1:0] miss_line,
    input  logic [OFF_W-1:0]   miss_off,
    output logic               miss_ready,
    output logic               mem_req_valid,
    output logic [LINE_AW-1:0] mem_req_line,
    output logic [OFF_W-1:0]   mem_req_off,
    input  logic               mem_req_ready,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_rready,
    output logic               cpu_rvalid,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               lw_en,
    output logic [OFF_W-1:0]   lw_idx,
    output logic [DATA_W-1:0]  lw_data,
    output logic               line_valid,
    input  logic               hit_valid,
    input  logic [LINE_AW-1:0] hit_line,
    input  logic [OFF_W-1:0]   hit_off,
    output logic               hit_stall
);
    typedef struct packed {
        fill_state_e        st;
        logic [LINE_AW-1:0] line;
        logic [OFF_W-1:0]   off;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic             miss_take;
    logic             beat_take;
    logic             seq_last;
    logic [OFF_W-1:0] seq_idx;
    logic             word_filled;
    logic             busy;

    assign miss_ready = (ctl_q.st == ST_IDLE);
    assign miss_take  = miss_valid && miss_ready;
    assign mem_rready = (ctl_q.st == ST_WAIT_CRIT) || (ctl_q.st == ST_FILL_REST);
    assign beat_take  = mem_rready && mem_rvalid;
    assign busy       = (ctl_q.st == ST_REQ) || mem_rready;

    cwf_beat_seq #(.WORDS(WORDS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (miss_take),
        .start_off (miss_off),
        .adv       (beat_take),
        .idx_o     (seq_idx),
        .last_o    (seq_last)
    );

    cwf_fill_mask #(.WORDS(WORDS)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (miss_take),
        .set_en    (beat_take),
        .set_idx   (seq_idx),
        .probe_idx (hit_off),
        .filled_o  (word_filled)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (miss_take) begin
                    ctl_d.st   = ST_REQ;
                    ctl_d.line = miss_line;
                    ctl_d.off  = miss_off;
                end
            end
            ST_REQ:       if (mem_req_ready) ctl_d.st = ST_WAIT_CRIT;
            ST_WAIT_CRIT: if (mem_rvalid)    ctl_d.st = ST_FILL_REST;
            ST_FILL_REST: if (mem_rvalid && seq_last) ctl_d.st = ST_DONE;
            ST_DONE:      ctl_d.st = ST_IDLE;
            default:      ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.line <= '0;
            ctl_q.off  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req_valid = (ctl_q.st == ST_REQ);
    assign mem_req_line  = ctl_q.line;
    assign mem_req_off   = ctl_q.off;

    assign lw_en   = beat_take;
    assign lw_idx  = seq_idx;
    assign lw_data = mem_rdata;

    assign cpu_rvalid = beat_take && (ctl_q.st == ST_WAIT_CRIT);
    assign cpu_rdata  = mem_rdata;

    assign line_valid = (ctl_q.st == ST_DONE);
    assign hit_stall  = hit_valid && busy && (hit_line == ctl_q.line) && !word_filled;
endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
    parameter int LINE_AW = 26,
    parameter int WORDS   = 8,
    parameter int DATA_W  = 32,
    localparam int OFF_W  = $clog2(WORDS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               miss_ready,
    input logic               mem_req_valid,
    input logic [LINE_AW-1:0] mem_req_line,
    input logic [OFF_W-1:0]   mem_req_off,
    input logic               mem_req_ready,
    input logic               mem_rvalid,
    input logic               mem_rready,
    input logic               cpu_rvalid,
    input logic [DATA_W-1:0]  cpu_rdata,
    input logic               lw_en,
    input logic [OFF_W-1:0]   lw_idx,
    input logic [DATA_W-1:0]  lw_data,
    input logic               line_valid,
    input logic               hit_stall
);
    // R6
    beat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en |-> (mem_rvalid && mem_rready));

    // R5
    early_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> (lw_en && lw_idx == mem_req_off && cpu_rdata == lw_data));

    // R5
    single_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);

    // R7
    line_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |=> !line_valid);

    // R2
    miss_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> !miss_ready);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_off) && $stable(mem_req_line)));

    // R10
    rready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> !mem_rready);

    // R8
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> !hit_stall);
endmodule

bind cwf_refill_ctrl cwf_refill_chk #(
    .LINE_AW (LINE_AW),
    .WORDS   (WORDS),
    .DATA_W  (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_ready    (miss_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_line  (mem_req_line),
    .mem_req_off   (mem_req_off),
    .mem_req_ready (mem_req_ready),
    .mem_rvalid    (mem_rvalid),
    .mem_rready    (mem_rready),
    .cpu_rvalid    (cpu_rvalid),
    .cpu_rdata     (cpu_rdata),
    .lw_en         (lw_en),
    .lw_idx        (lw_idx),
    .lw_data       (lw_data),
    .line_valid    (line_valid),
    .hit_stall     (hit_stall)
);

// File: tb/cwf_refill_ctrl_test.sv
`timescale 1ns/1ps
module cwf_refill_ctrl_test;
    localparam int LINE_AW = 26;
    localparam int WORDS   = 8;
    localparam int DATA_W  = 32;
    localparam int OFF_W   = $clog2(WORDS);

    logic               clk = 1'b0;
    logic               rst_n;
    logic               miss_valid;
    logic [LINE_AW-1:0] miss_line;
    logic [OFF_W-1:0]   miss_off;
    logic               miss_ready;
    logic               mem_req_valid;
    logic [LINE_AW-1:0] mem_req_line;
    logic [OFF_W-1:0]   mem_req_off;
    logic               mem_req_ready;
    logic               mem_rvalid;
    logic [DATA_W-1:0]  mem_rdata;
    logic               mem_rready;
    logic               cpu_rvalid;
    logic [DATA_W-1:0]  cpu_rdata;
    logic               lw_en;
    logic [OFF_W-1:0]   lw_idx;
    logic [DATA_W-1:0]  lw_data;
    logic               line_valid;
    logic               hit_valid;
    logic [LINE_AW-1:0] hit_line;
    logic [OFF_W-1:0]   hit_off;
    logic               hit_stall;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] store [WORDS];

    always #2 clk = ~clk;

    cwf_refill_ctrl #(.LINE_AW(LINE_AW), .WORDS(WORDS), .DATA_W(DATA_W)) uut (.*);

    function automatic logic [DATA_W-1:0] word_of(input logic [LINE_AW-1:0] ln, input int idx);
        return (DATA_W'(ln) << 8) ^ (DATA_W'(idx) * 32'h0101_0101) ^ 32'hA500_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_miss(input int off, input int gapsel);
        logic [LINE_AW-1:0] ln;
        int idx;
        ln = LINE_AW'(32'h100 + off * 7 + gapsel);
        for (int w = 0; w < WORDS; w++) store[w] = 32'hDEAD_0000;
        @(posedge clk); #1;
        miss_valid = 1'b1; miss_line = ln; miss_off = OFF_W'(off);
        @(negedge clk);
        chk(miss_ready == 1'b1, "R2 ready before accept", 32'(miss_ready), 1);
        @(posedge clk); #1;
        miss_valid = 1'b0;
        @(negedge clk);
        chk(mem_req_valid && mem_req_line == ln && mem_req_off == OFF_W'(off),
            "R3 request line/offset", 32'(mem_req_off), 32'(off));
        chk(miss_ready == 1'b0, "R2 ready low in fill", 32'(miss_ready), 0);
        chk(mem_rready == 1'b0, "R10 rready low before grant", 32'(mem_rready), 0);
        @(posedge clk); #1;
        mem_req_ready = 1'b1;
        @(negedge clk);
        chk(mem_req_valid && mem_req_off == OFF_W'(off), "R9 request held", 32'(mem_req_valid), 1);
        @(posedge clk); #1;
        mem_req_ready = 1'b0;
        for (int k = 0; k < WORDS; k++) begin
            idx = (off + k) % WORDS;
            if (gapsel != 0 && ((k + off + gapsel) % 3 == 0)) begin
                mem_rvalid = 1'b0;
                @(negedge clk);
                chk(lw_en == 1'b0 && cpu_rvalid == 1'b0, "R6 no write on gap", 32'(lw_en), 0);
                chk(mem_rready == 1'b1, "R10 rready during fill", 32'(mem_rready), 1);
                @(posedge clk); #1;
            end
            mem_rvalid = 1'b1;
            mem_rdata  = word_of(ln, idx);
            if (k == 3) begin
                hit_valid = 1'b1; hit_line = ln; hit_off = OFF_W'((off + 5) % WORDS);
                @(negedge clk);
                chk(hit_stall == 1'b1, "R8 stall unwritten word", 32'(hit_stall), 1);
                hit_off = OFF_W'((off + 1) % WORDS);
                #0.2;
                chk(hit_stall == 1'b0, "R8 written word served", 32'(hit_stall), 0);
                hit_line = ln + 1'b1; hit_off = OFF_W'((off + 6) % WORDS);
                #0.2;
                chk(hit_stall == 1'b0, "R8 other line not stalled", 32'(hit_stall), 0);
                hit_valid = 1'b0;
                #0.2;
            end else begin
                @(negedge clk);
            end
            chk(lw_en == 1'b1 && lw_idx == OFF_W'(idx), "R4 write order", 32'(lw_idx), 32'(idx));
            chk(lw_data == word_of(ln, idx), "R4 write data", lw_data, word_of(ln, idx));
            chk(cpu_rvalid == (k == 0), "R5 restart strobe cycle", 32'(cpu_rvalid), 32'(k == 0));
            if (k == 0)
                chk(cpu_rdata == word_of(ln, off), "R5 restart data", cpu_rdata, word_of(ln, off));
            chk(line_valid == 1'b0, "R7 no early valid", 32'(line_valid), 0);
            if (lw_en) store[lw_idx] = lw_data;
            @(posedge clk); #1;
        end
        mem_rvalid = 1'b0;
        @(negedge clk);
        chk(line_valid == 1'b1, "R7 valid after last beat", 32'(line_valid), 1);
        chk(miss_ready == 1'b0, "R2 ready low in done", 32'(miss_ready), 0);
        chk(mem_rready == 1'b0, "R10 rready low after fill", 32'(mem_rready), 0);
        @(posedge clk); #1;
        @(negedge clk);
        chk(line_valid == 1'b0, "R7 valid one cycle", 32'(line_valid), 0);
        chk(miss_ready == 1'b1, "R2 ready after fill", 32'(miss_ready), 1);
        for (int w = 0; w < WORDS; w++)
            chk(store[w] == word_of(ln, w), "R4 final line contents", store[w], word_of(ln, w));
    endtask

    initial begin
        rst_n = 1'b0; miss_valid = 1'b0; miss_line = '0; miss_off = '0;
        mem_req_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        hit_valid = 1'b0; hit_line = '0; hit_off = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(miss_ready == 1'b1, "R1 reset miss_ready", 32'(miss_ready), 1);
        chk(!mem_req_valid && !mem_rready && !lw_en && !cpu_rvalid && !line_valid,
            "R1 reset outputs idle", 32'({mem_req_valid, mem_rready, lw_en, cpu_rvalid, line_valid}), 0);
        hit_valid = 1'b1; hit_line = '0; hit_off = '0;
        #0.2;
        chk(hit_stall == 1'b0, "R8 no stall when idle", 32'(hit_stall), 0);
        hit_valid = 1'b0;
        for (int g = 0; g < 2; g++)
            for (int o = 0; o < WORDS; o++)
                run_miss(o, g);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule